// File: doc/BRIEF.md
# Procedure Frame Link Controller

This block keeps the call history of a stack that lives in memory. Each procedure frame starts with a mark word. Every mark word holds a backward displacement to the mark word before it, so the frames form a chain. A frame register (F) points at the newest mark word, which is the head of that chain. A stack pointer (S) points at the last word in use.

On a procedure call the block writes a new mark word just above S and moves both S and F onto it. Words that are pushed afterwards hold the procedure's parameters and locals. These are reached by a small adder that offsets from F. On return the block reads the current mark word, drops S to the word just below it and steps F back along the stored displacement. Both operations take a single memory cycle. Busy is held high during that cycle, and requests that arrive while busy is high are dropped.

Top module: `frame_link_ctrl`

## Requirements
- R1: After reset S and F both equal the parameter BASE_ADDR, and busy, err, mem_we and mem_re are all low.
- R2: An accepted call asserts mem_we and busy for exactly the next cycle. In that cycle mem_addr is old S + 1, and mem_wdata carries the mark tag 3'b011 in its top three bits, the displacement (old S + 1) − old F in bits [AW-1:0], and zeros in all other bits.
- R3: After an accepted call both S and F equal old S + 1.
- R4: A push request accepted while idle increments S by one and leaves F unchanged.
- R5: An accepted return asserts mem_re and busy for exactly the next cycle with mem_addr = F. At the end of that cycle S becomes that F − 1.
- R6: At the end of the return read cycle, F becomes the old F minus the displacement held in bits [AW-1:0] of the word read, which is the previous mark word's address.
- R7: A return requested while F equals BASE_ADDR raises err for one cycle. It leaves S and F unchanged and makes no memory access.
- R8: ref_addr always equals F + ref_offset, modulo 2^AW, combinationally.
- R9: Requests that arrive while busy is high have no effect. When several requests arrive together while idle, a call wins over a return, and a return wins over a push.
- R10: F never exceeds S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Procedure call request |
| exit_req | input | 1 | Procedure return request |
| push_req | input | 1 | Place one more word above S |
| ref_offset | input | AW | Offset of a parameter or local from F |
| ref_addr | output | AW | Resolved absolute address F + offset |
| mem_we | output | 1 | Memory write strobe (mark word) |
| mem_re | output | 1 | Memory read strobe (mark word fetch) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Mark word written on a call |
| mem_rdata | input | DW | Read data, valid in the same cycle as mem_re |
| sp | output | AW | Stack pointer S |
| fp | output | AW | Frame register F |
| busy | output | 1 | Memory cycle in progress |
| err | output | 1 | Return attempted at the stack base |

## Verification
The assertions assume that memory returns the read word combinationally in the mem_re cycle. They also assume that any word fetched at F is a mark word that this block wrote earlier, so its tag and zero padding are intact. The stimulus meets both conditions. The bench memory has an asynchronous read and is written only by the block. In addition, random calls and pushes stop once S nears the top of the address space, so S never wraps.

// File: rtl/frame_link_pkg.sv
package frame_link_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } fl_state_e;

    localparam logic [2:0] MARK_TAG = 3'b011;
endpackage

// File: rtl/frame_ref_resolve.sv
module frame_ref_resolve #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] fp,
    input  logic [AW-1:0] ofs,
    output logic [AW-1:0] addr
);
    always_comb begin
        addr = fp + ofs;
    end
endmodule

// File: rtl/frame_cmd_arb.sv
module frame_cmd_arb #(
    parameter int AW = 8,
    parameter int BASE_ADDR = 16
) (
    input  logic          enter_req,
    input  logic          exit_req,
    input  logic          push_req,
    input  logic          busy,
    input  logic [AW-1:0] fp,
    output logic          go_enter,
    output logic          go_exit,
    output logic          go_push,
    output logic          go_err
);
    localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);

    logic idle;
    logic at_base;

    always_comb begin
        idle     = !busy;
        at_base  = (fp == BASE);
        go_enter = idle && enter_req;
        go_exit  = idle && !enter_req && exit_req && !at_base;
        go_err   = idle && !enter_req && exit_req && at_base;
        go_push  = idle && !enter_req && !exit_req && push_req;
    end

    always_comb begin
        assert ($countones({go_enter, go_exit, go_push, go_err}) <= 1)
            else $error("AST_ONE_GRANT"); // R9
    end
endmodule

// File: rtl/frame_link_ctrl.sv
module frame_link_ctrl
    import frame_link_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int BASE_ADDR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter_req,
    input  logic          exit_req,
    input  logic          push_req,
    input  logic [AW-1:0] ref_offset,
    output logic [AW-1:0] ref_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] fp,
    output logic          busy,
    output logic          err
);
    localparam int PAD = DW - AW - 3;
    localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);
    localparam logic [AW-1:0] ONE  = AW'(1);

    typedef struct packed {
        fl_state_e     state;
        logic [AW-1:0] sp;
        logic [AW-1:0] fp;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          err;
    } regs_t;

    regs_t r_q, r_d;
    logic go_enter, go_exit, go_push, go_err;
    logic [AW-1:0] nsp_d;
    logic [AW-1:0] disp_d;

    frame_cmd_arb #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_arb (
        .enter_req (enter_req),
        .exit_req  (exit_req),
        .push_req  (push_req),
        .busy      (busy),
        .fp        (r_q.fp),
        .go_enter  (go_enter),
        .go_exit   (go_exit),
        .go_push   (go_push),
        .go_err    (go_err)
    );

    frame_ref_resolve #(.AW(AW)) u_ref (
        .fp   (r_q.fp),
        .ofs  (ref_offset),
        .addr (ref_addr)
    );

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        nsp_d   = r_q.sp + ONE;
        disp_d  = nsp_d - r_q.fp;
        case (r_q.state)
            ST_IDLE: begin
                if (go_enter) begin
                    r_d.state = ST_WRITE;
                    r_d.sp    = nsp_d;
                    r_d.fp    = nsp_d;
                    r_d.addr  = nsp_d;
                    r_d.wdata = {MARK_TAG, {PAD{1'b0}}, disp_d};
                end else if (go_exit) begin
                    r_d.state = ST_READ;
                    r_d.addr  = r_q.fp;
                end else if (go_push) begin
                    r_d.sp    = nsp_d;
                end else if (go_err) begin
                    r_d.err   = 1'b1;
                end
            end
            ST_WRITE: r_d.state = ST_IDLE;
            ST_READ: begin
                r_d.state = ST_IDLE;
                r_d.sp    = r_q.fp - ONE;
                r_d.fp    = r_q.fp - mem_rdata[AW-1:0];
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.sp    <= BASE;
            r_q.fp    <= BASE;
            r_q.addr  <= BASE;
            r_q.wdata <= '0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we    = (r_q.state == ST_WRITE);
    assign mem_re    = (r_q.state == ST_READ);
    assign busy      = (r_q.state != ST_IDLE);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign sp        = r_q.sp;
    assign fp        = r_q.fp;
    assign err       = r_q.err;

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy) else $error("AST_BUSY_SINGLE"); // R2
    AST_NO_WE_RE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)) else $error("AST_NO_WE_RE"); // R5
    AST_CALL_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (fp == sp && mem_addr == fp)) else $error("AST_CALL_HEAD"); // R3
    AST_RET_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp == $past(fp) - ONE)) else $error("AST_RET_SP"); // R5
    AST_RET_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_rdata[DW-1:AW] == {MARK_TAG, {PAD{1'b0}}})) else $error("AST_RET_MARK"); // R6
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (sp == $past(sp) && fp == $past(fp) && !busy)) else $error("AST_ERR_HOLD"); // R7
    AST_FP_BELOW_SP: assert property (@(posedge clk) disable iff (!rst_n)
        fp <= sp) else $error("AST_FP_BELOW_SP"); // R10
endmodule

// File: tb/sim_frame_link_ctrl.sv
module sim_frame_link_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int BASE = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_req = 0, exit_req = 0, push_req = 0;
    logic [AW-1:0] ref_offset = '0;
    logic [AW-1:0] ref_addr, mem_addr, sp, fp;
    logic mem_we, mem_re, busy, err;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [DW-1:0] mem [0:(1<<AW)-1];

    int checks = 0, errors = 0;
    bit done = 0;
    int mS, mF;
    int fstk [0:255];
    int depth = 0;

    always #5 clk = ~clk;

    frame_link_ctrl #(.AW(AW), .DW(DW), .BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .push_req(push_req), .ref_offset(ref_offset), .ref_addr(ref_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp(sp), .fp(fp),
        .busy(busy), .err(err)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    function automatic logic [DW-1:0] mark_word(int disp);
        return {3'b011, {(DW-AW-3){1'b0}}, AW'(disp)};
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(bit en, bit ex, bit pu);
        enter_req = en; exit_req = ex; push_req = pu;
        @(negedge clk);
        enter_req = 0; exit_req = 0; push_req = 0;
    endtask

    task automatic do_enter();
        int ns = mS + 1;
        step(1, 0, 0);
        chk("R2 busy", busy, 1); chk("R2 we", mem_we, 1);
        chk("R2 addr", mem_addr, ns); chk("R2 word", mem_wdata, mark_word(ns - mF));
        fstk[depth] = mF; depth++;
        mS = ns; mF = ns;
        step(0, 0, 0);
        chk("R2 busy drop", busy, 0);
        chk("R3 sp", sp, mS); chk("R3 fp", fp, mF);
    endtask

    task automatic do_exit();
        if (mF == BASE) begin
            step(0, 1, 0);
            chk("R7 err", err, 1); chk("R7 re", mem_re, 0);
            chk("R7 sp", sp, mS); chk("R7 fp", fp, mF);
            step(0, 0, 0);
            chk("R7 err pulse", err, 0);
        end else begin
            step(0, 1, 0);
            chk("R5 busy", busy, 1); chk("R5 re", mem_re, 1);
            chk("R5 addr", mem_addr, mF);
            step(0, 0, 0);
            mS = mF - 1; depth--; mF = fstk[depth];
            chk("R5 sp", sp, mS); chk("R6 fp", fp, mF);
        end
    endtask

    task automatic do_push();
        step(0, 0, 1);
        mS++;
        chk("R4 sp", sp, mS); chk("R4 fp", fp, mF);
    endtask

    task automatic do_ref(int ofs);
        ref_offset = AW'(ofs);
        #1;
        chk("R8 ref", ref_addr, (mF + ofs) % (1 << AW));
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        mS = BASE; mF = BASE;
        chk("R1 sp", sp, BASE); chk("R1 fp", fp, BASE);
        chk("R1 busy", busy, 0); chk("R1 err", err, 0);
        chk("R1 we", mem_we, 0); chk("R1 re", mem_re, 0);

        do_exit();                     // R7 at base
        do_enter();
        do_push(); do_push(); do_push();
        do_ref(1); do_ref(3); do_ref(250);
        // R9: requests during busy are dropped
        step(1, 0, 0);
        fstk[depth] = mF; depth++; mS = mS + 1; mF = mS;
        step(1, 1, 1);
        chk("R9 busy ignore sp", sp, mS); chk("R9 busy ignore fp", fp, mF);
        chk("R9 busy ignore idle", busy, 0);
        // R9: call beats return and push
        step(1, 1, 1);
        chk("R9 prio we", mem_we, 1);
        fstk[depth] = mF; depth++; mS = mS + 1; mF = mS;
        step(0, 0, 0);
        chk("R9 prio sp", sp, mS);
        // R9: return beats push
        step(0, 1, 1);
        chk("R9 ret prio re", mem_re, 1);
        step(0, 0, 0);
        mS = mF - 1; depth--; mF = fstk[depth];
        chk("R9 ret prio sp", sp, mS); chk("R9 ret prio fp", fp, mF);
        do_exit(); do_exit(); do_exit();

        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 9);
            if (mS > 230 && op < 7) op = 8;
            if (op < 3) do_enter();
            else if (op < 7) do_push();
            else do_exit();
            do_ref($urandom_range(0, 20));
            checks++;
            if (fp > sp) begin
                errors++;
                $display("FAIL R10 actual=%0d expected<=%0d", fp, sp);
            end
        end
        while (mF != BASE) do_exit();
        do_exit();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule